// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

An 8-bit timer/counter that advances on enable pulses taken from a free-running prescaler on the system clock, or from an external clock-enable input. Software reaches a control register, the count register and a compare register through a simple synchronous register port. The counter raises one-cycle overflow and compare-match event pulses that an interrupt controller can latch. It can also drive a single waveform pin, either as a match-driven output or as a phase-correct PWM signal.

In normal mode the counter counts up and wraps. It can optionally be cleared when it matches the compare value. In PWM mode it counts up to 0xFF, then back down to 0x00. A typical use presets the count so that the overflow event comes after a chosen number of prescaled ticks. For example, a preset of 0xB2 at divide-by-256 gives an overflow 78 ticks later.

Top module: `tmr8_top`

## Requirements
- R1: After reset the control, count and compare registers read 0x00, and `ovf_evt`, `cmp_evt` and `wave_out` are low.
- R2: Register addresses are 0 for control, 1 for count and 2 for compare, and address 3 reads 0x00. A write is taken on the clock edge where `bus_wr` is high. `bus_rdata` shows the addressed register in the same cycle. The control fields are: [2:0] clock select, [3] clear on match, [4] PWM enable, [6:5] output mode, [7] external source.
- R3: A 10-bit prescaler counts every clock from 0 after reset. Clock select maps as follows: 0 stops the counter, 1 gives a tick every clock, and 2, 3, 4, 5, 6 and 7 give a tick when the low 3, 5, 6, 7, 8 and 10 prescaler bits are all ones. These correspond to /8, /32, /64, /128, /256 and /1024.
- R4: When control bit 7 is set, each cycle with `ext_tick` high is a tick and the clock-select field is ignored.
- R5: A count write loads the value on that edge and takes priority over a tick in the same cycle. The value then holds until the next tick.
- R6: In normal mode a tick at 0xFF wraps the count to 0x00, and `ovf_evt` is high for exactly the following cycle.
- R7: In normal mode, with clear-on-match set, a tick while count equals compare sets the count to 0x00. That tick raises no overflow event.
- R8: A tick (without a count write) while count equals compare raises `cmp_evt` for the following cycle, in any mode.
- R9: In PWM mode the counter counts up to 0xFF, then steps to 0xFE and counts down. At 0x00 it steps to 0x01 and counts up. The tick at 0x00 raises `ovf_evt`. Clear-on-match has no effect in PWM mode.
- R10: In normal mode a compare event updates the pin: output mode 1 toggles it, mode 2 clears it and mode 3 sets it. With mode 0, `wave_out` is held low.
- R11: In PWM mode with output mode 2, a compare event clears the pin while counting up and sets it while counting down. Mode 3 does the opposite. Modes 0 and 1 hold `wave_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| ext_tick | input | 1 | External clock-enable pulse |
| ovf_evt | output | 1 | Overflow event pulse |
| cmp_evt | output | 1 | Compare-match event pulse |
| wave_out | output | 1 | Compare / PWM waveform pin |

## Verification
Random control words mostly select fast prescaler taps. They are mixed with random count and compare writes and random external pulses, so the bench sees wraps, clear-on-match cycles, up/down turnarounds and every pin mode. A per-cycle reference model compares each of these against the design. The 0xB2 preset at divide-by-256 separates a correct tap and a correct wrap point from tap or wrap errors, which would move the overflow by whole ticks. A stopped counter with a preset value shows that writes hold, and external pulses with the clock select set to a fast tap show that the source select overrides the tap. A short clear-on-match run shows that the count never passes the compare value and raises no overflow.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int CNT_W = 8;
    localparam int PRE_W = 10;
    localparam int SEL_N = 8;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_CMP  = 2'd2;

    typedef enum logic [1:0] {
        OM_OFF = 2'd0,
        OM_TGL = 2'd1,
        OM_CLR = 2'd2,
        OM_SET = 2'd3
    } omode_e;

    typedef struct packed {
        logic       ext_sel;
        omode_e     omode;
        logic       pwm_en;
        logic       ctc_en;
        logic [2:0] csel;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
        logic             ovf;
        logic             cev;
    } core_st_t;

    // prescaler bits that must be all ones for a tick at each select value
    function automatic int tap_bits(input int sel);
        case (sel)
            1: return 0;
            2: return 3;
            3: return 5;
            4: return 6;
            5: return 7;
            6: return 8;
            default: return 10;
        endcase
    endfunction
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
    import tmr8_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] csel,
    input  logic       ext_sel,
    input  logic       ext_tick,
    output logic       tick
);
    logic [W-1:0] pre_d, pre_q;
    logic [SEL_N-1:0] tap;

    always_comb begin
        pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tap[0] = 1'b0;
    for (genvar g = 1; g < SEL_N; g++) begin : g_tap
        localparam int SH = tap_bits(g);
        if (SH == 0) begin : g_every
            assign tap[g] = 1'b1;
        end else begin : g_div
            assign tap[g] = &pre_q[SH-1:0];
        end
    end

    assign tick = ext_sel ? ext_tick : tap[csel];
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_cnt,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cmp_val,
    input  logic         ctc_en,
    input  logic         pwm_en,
    output logic [W-1:0] cnt,
    output logic         up,
    output logic         match_ev,
    output logic         ovf_o,
    output logic         cev_o
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] BOT = '0;

    core_st_t st_d, st_q;
    logic     eq;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.cev = 1'b0;
        eq       = (st_q.cnt == cmp_val);
        match_ev = 1'b0;
        if (wr_cnt) begin
            st_d.cnt = wdata;
        end else if (tick) begin
            match_ev = eq;
            st_d.cev = eq;
            if (pwm_en) begin
                if (st_q.up) begin
                    if (st_q.cnt == TOP) begin
                        st_d.up  = 1'b0;
                        st_d.cnt = TOP - 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end else begin
                    if (st_q.cnt == BOT) begin
                        st_d.up  = 1'b1;
                        st_d.cnt = BOT + 1'b1;
                        st_d.ovf = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end else if (ctc_en && eq) begin
                st_d.cnt = BOT;
            end else begin
                st_d.ovf = (st_q.cnt == TOP);
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (!pwm_en) st_d.up = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0, up: 1'b1, ovf: 1'b0, cev: 1'b0};
        else        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign up    = st_q.up;
    assign ovf_o = st_q.ovf;
    assign cev_o = st_q.cev;
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
    import tmr8_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   match_ev,
    input  logic   up,
    input  logic   pwm_en,
    input  omode_e omode,
    output logic   pin
);
    logic pin_d, pin_q;
    logic drive;

    always_comb begin
        pin_d = pin_q;
        if (match_ev) begin
            if (!pwm_en) begin
                case (omode)
                    OM_TGL:  pin_d = ~pin_q;
                    OM_CLR:  pin_d = 1'b0;
                    OM_SET:  pin_d = 1'b1;
                    default: pin_d = pin_q;
                endcase
            end else begin
                case (omode)
                    OM_CLR:  pin_d = ~up;
                    OM_SET:  pin_d = up;
                    default: pin_d = pin_q;
                endcase
            end
        end
        drive = (omode != OM_OFF) && !(pwm_en && omode == OM_TGL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign pin = drive & pin_q;
endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
    import tmr8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_tick,
    output logic       ovf_evt,
    output logic       cmp_evt,
    output logic       wave_out
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cmpr;
    } regs_t;

    regs_t            rg_d, rg_q;
    logic             tick_w;
    logic             wr_cnt_w;
    logic [CNT_W-1:0] cnt_w;
    logic             up_w;
    logic             match_w;

    always_comb begin
        rg_d     = rg_q;
        wr_cnt_w = bus_wr && (bus_addr == A_CNT);
        if (bus_wr && bus_addr == A_CTRL) rg_d.ctrl = ctrl_t'(bus_wdata);
        if (bus_wr && bus_addr == A_CMP)  rg_d.cmpr = bus_wdata;
        case (bus_addr)
            A_CTRL:  bus_rdata = rg_q.ctrl;
            A_CNT:   bus_rdata = cnt_w;
            A_CMP:   bus_rdata = rg_q.cmpr;
            default: bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    tmr8_prescaler #(.W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .csel     (rg_q.ctrl.csel),
        .ext_sel  (rg_q.ctrl.ext_sel),
        .ext_tick (ext_tick),
        .tick     (tick_w)
    );

    tmr8_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .wr_cnt   (wr_cnt_w),
        .wdata    (bus_wdata),
        .cmp_val  (rg_q.cmpr),
        .ctc_en   (rg_q.ctrl.ctc_en),
        .pwm_en   (rg_q.ctrl.pwm_en),
        .cnt      (cnt_w),
        .up       (up_w),
        .match_ev (match_w),
        .ovf_o    (ovf_evt),
        .cev_o    (cmp_evt)
    );

    tmr8_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_ev (match_w),
        .up       (up_w),
        .pwm_en   (rg_q.ctrl.pwm_en),
        .omode    (rg_q.ctrl.omode),
        .pin      (wave_out)
    );
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_cnt,
    input logic [7:0] wdata,
    input logic [7:0] cnt,
    input logic [7:0] cmpr,
    input logic       pwm_en,
    input logic       ctc_en,
    input logic       up,
    input logic       ovf,
    input logic       cmp_ev
);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt));

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wdata)));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && !pwm_en && cnt == 8'hFF && !(ctc_en && cmpr == 8'hFF))
        |=> (cnt == 8'h00 && ovf));

    assert_one_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf);

    assert_ctc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && !pwm_en && ctc_en && cnt == cmpr)
        |=> (cnt == 8'h00 && !ovf));

    assert_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && cnt == cmpr) |=> cmp_ev);

    assert_turn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && pwm_en && up && cnt == 8'hFF) |=> (cnt == 8'hFE && !up));
endmodule

bind tmr8_top tmr8_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_w),
    .wr_cnt (wr_cnt_w),
    .wdata  (bus_wdata),
    .cnt    (cnt_w),
    .cmpr   (rg_q.cmpr),
    .pwm_en (rg_q.ctrl.pwm_en),
    .ctc_en (rg_q.ctrl.ctc_en),
    .up     (up_w),
    .ovf    (ovf_evt),
    .cmp_ev (cmp_evt)
);

// File: tb/tmr8_top_tb.sv
module tmr8_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext_tick = 1'b0;
    logic       ovf_evt, cmp_evt, wave_out;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tmr8_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
        .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .wave_out(wave_out)
    );

    // reference model built from the requirements
    logic [9:0] m_pre;
    logic [7:0] m_ctrl, m_cnt, m_cmp;
    logic       m_up, m_ovf, m_cev, m_pin;

    function automatic int shift_of(input logic [2:0] s);
        case (s)
            3'd1: return 0;
            3'd2: return 3;
            3'd3: return 5;
            3'd4: return 6;
            3'd5: return 7;
            3'd6: return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic model_tick(input logic [7:0] c, input logic [9:0] p, input logic e);
        int sh;
        if (c[7]) return e;
        if (c[2:0] == 3'd0) return 1'b0;
        sh = shift_of(c[2:0]);
        return ((int'(p) & ((1 << sh) - 1)) == ((1 << sh) - 1));
    endfunction

    function automatic logic model_wave(input logic [7:0] c, input logic p);
        if (c[6:5] == 2'd0) return 1'b0;
        if (c[4] && c[6:5] == 2'd1) return 1'b0;
        return p;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = '0; m_ctrl = '0; m_cnt = '0; m_cmp = '0;
            m_up = 1'b1; m_ovf = 1'b0; m_cev = 1'b0; m_pin = 1'b0;
        end else begin
            logic t, mt;
            t = model_tick(m_ctrl, m_pre, ext_tick);
            m_ovf = 1'b0;
            m_cev = 1'b0;
            if (bus_wr && bus_addr == 2'd1) begin
                m_cnt = bus_wdata;
            end else if (t) begin
                mt = (m_cnt == m_cmp);
                m_cev = mt;
                if (mt) begin
                    if (!m_ctrl[4]) begin
                        case (m_ctrl[6:5])
                            2'd1: m_pin = ~m_pin;
                            2'd2: m_pin = 1'b0;
                            2'd3: m_pin = 1'b1;
                            default: ;
                        endcase
                    end else begin
                        if (m_ctrl[6:5] == 2'd2) m_pin = ~m_up;
                        if (m_ctrl[6:5] == 2'd3) m_pin = m_up;
                    end
                end
                if (m_ctrl[4]) begin
                    if (m_up) begin
                        if (m_cnt == 8'hFF) begin m_up = 1'b0; m_cnt = 8'hFE; end
                        else m_cnt = m_cnt + 8'd1;
                    end else begin
                        if (m_cnt == 8'h00) begin m_up = 1'b1; m_cnt = 8'h01; m_ovf = 1'b1; end
                        else m_cnt = m_cnt - 8'd1;
                    end
                end else if (m_ctrl[3] && mt) begin
                    m_cnt = 8'h00;
                end else begin
                    m_ovf = (m_cnt == 8'hFF);
                    m_cnt = m_cnt + 8'd1;
                end
            end
            if (!m_ctrl[4]) m_up = 1'b1;
            if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata;
            if (bus_wr && bus_addr == 2'd2) m_cmp = bus_wdata;
            m_pre = m_pre + 10'd1;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_ctrl;
            2'd1: return m_cnt;
            2'd2: return m_cmp;
            default: return 8'h00;
        endcase
    endfunction

    // advance one cycle and compare every output with the model
    task automatic step();
        @(negedge clk);
        check("R2 rdata", bus_rdata, model_read(bus_addr));
        check(m_ctrl[4] ? "R9 ovf" : "R6 ovf", {7'd0, ovf_evt}, {7'd0, m_ovf});
        check("R8 cmp_evt", {7'd0, cmp_evt}, {7'd0, m_cev});
        check(m_ctrl[4] ? "R11 wave" : "R10 wave", {7'd0, wave_out},
              {7'd0, model_wave(m_ctrl, m_pin)});
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_addr = 2'd1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #1;
            check("R1 reset reg", bus_rdata, 8'h00);
        end
        check("R1 reset outs", {5'd0, ovf_evt, cmp_evt, wave_out}, 8'h00);
        bus_addr = 2'd1;

        // R2 register read back
        wr(2'd2, 8'h5A);
        bus_addr = 2'd2; #1;
        check("R2 compare readback", bus_rdata, 8'h5A);

        // R5 stopped counter holds written value
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h40);
        repeat (20) step();
        check("R5 hold value", bus_rdata, 8'h40);

        // R4 external pulses counted, clock select ignored
        wr(2'd0, 8'h81);
        for (int i = 0; i < 5; i++) begin
            ext_tick = 1'b1; step();
            ext_tick = 1'b0; step(); step();
        end
        check("R4 external count", bus_rdata, 8'h45);

        // R7 clear on match at full rate
        wr(2'd2, 8'h10);
        wr(2'd0, 8'h09);
        wr(2'd1, 8'h00);
        begin
            logic over;
            over = 1'b0;
            for (int i = 0; i < 60; i++) begin
                step();
                if (bus_rdata > 8'h10 || ovf_evt) over = 1'b1;
            end
            check("R7 never past compare", {7'd0, over}, 8'h00);
        end

        // R3 preset 0xB2 at /256 overflows after 78 ticks
        wr(2'd0, 8'h06);
        wr(2'd1, 8'hB2);
        begin
            int n;
            n = 0;
            while (!ovf_evt && n < 30000) begin step(); n++; end
            check("R3 overflow window",
                  {7'd0, (n > 77 * 256) && (n <= 78 * 256)}, 8'h01);
        end

        // R9 / R11 directed PWM sweep at full rate
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h51);
        repeat (1200) step();

        // random mix
        for (int i = 0; i < 25000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            ext_tick = 1'($urandom_range(0, 1));
            if (r < 2) begin
                logic [7:0] c;
                c = 8'($urandom);
                c[2:0] = 3'($urandom_range(1, 3));
                if ($urandom_range(0, 9) == 0) c[7] = 1'b1; else c[7] = 1'b0;
                wr(2'd0, c);
            end else if (r < 4) begin
                wr(2'd2, 8'($urandom));
            end else if (r < 5) begin
                wr(2'd1, 8'($urandom));
            end else begin
                bus_addr = 2'($urandom_range(0, 3));
                step();
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule